// File: doc/BRIEF.md
# Accumulator Right Shift Unit

This execution unit shifts a 32-bit accumulator right by a count taken from the low nibble of a 16-bit count register. It then updates the zero, negative and carry flags from the result. A mode bit chooses between two kinds of fill for the vacated upper bits: with the bit set the shift is arithmetic and copies of the old bit 31 fill them, and with the bit clear the shift is logical and zeros fill them.

The operation is started by a one-cycle strobe. An 8-bit repeat count N runs the same shift N+1 times, one pass per clock. The count and mode are captured at start and reused for every pass. A one-cycle done pulse marks the final pass. A separate combinational comparator flags an opcode word that selects this operation.

Top module: `acc_rshift_unit`

## Requirements
- R1: The shift amount is cnt_i[3:0] (0 to 15). Bits cnt_i[15:4] have no effect on the result or the flags.
- R2: When sxm_i is 1, the vacated upper bits are filled with the original bit 31 (arithmetic shift). When sxm_i is 0, they are filled with zeros (logical shift).
- R3: After every pass, z_o is 1 exactly when the 32-bit result is zero. This also holds for a shift amount of 0.
- R4: After every pass, n_o equals bit 31 of the result. This also holds for a shift amount of 0.
- R5: c_o is 0 after a pass with amount 0. Otherwise c_o is the last bit shifted out, which is bit (amount-1) of that pass's input.
- R6: With rpt_i = N, the shift is applied N+1 times, one pass per clock, each with the same amount. The flags reflect the last pass.
- R7: With rpt_i = 0, the result, the flags and done_o appear one clock after the start edge. done_o is high for exactly one cycle, on the cycle after the final pass.
- R8: The count, mode and accumulator inputs are sampled only at an accepted start. A start strobe while an operation is still running is ignored.
- R9: match_o is 1 combinationally exactly when opcode_i equals 16'hFF51.
- R10: While rst_ni is low, acc_o, z_o, n_o, c_o and done_o are 0 and no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| acc_i | input | 32 | Accumulator operand |
| cnt_i | input | 16 | Count register, low nibble used |
| sxm_i | input | 1 | 1: arithmetic shift, 0: logical shift |
| rpt_i | input | 8 | Repeat count N, giving N+1 passes |
| opcode_i | input | 16 | Opcode word to compare |
| acc_o | output | 32 | Accumulator result |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry flag |
| done_o | output | 1 | Final-pass pulse |
| match_o | output | 1 | Opcode match |

## Verification
The assertions check the following on every cycle:
- Z and N agree with the accumulator whenever done is high.
- A zero-amount start leaves carry clear.
- The fill bit matches the mode on a single accepted start.
- A start with no repeat produces done one clock later.
- done and the internal busy state are never high together.

Only the bench scenarios can show the rest:
- The exact pass count under long repeats.
- That mid-operation changes to the count, mode and strobe are ignored.
- That the upper count bits are ignored.
- That carry picks the right bit for a given amount.

The bench shows these by comparing against a bit-serial model at every clock.

// File: rtl/acc_rshift_pkg.sv
package acc_rshift_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int AMT_W  = 4;
  localparam int RPT_W  = 8;
  localparam int OPC_W  = 16;
  localparam logic [OPC_W-1:0] OPC_SFR = 16'hFF51;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_rshift_core.sv
// Log-depth right shifter that tracks the last bit shifted out.
module acc_rshift_core #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 4
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              cout_o
);
  logic [AMT_W:0][DATA_W-1:0] stg;
  logic [AMT_W:0]             cy;
  logic                       fill;

  assign fill   = arith_i & din_i[DATA_W-1];
  assign stg[0] = din_i;
  assign cy[0]  = 1'b0;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{SH{fill}}, stg[s][DATA_W-1:SH]} : stg[s];
    // the highest active stage shifts last, so its top-out bit is the carry
    assign cy[s+1]  = amt_i[s] ? stg[s][SH-1] : cy[s];
  end

  assign dout_o = stg[AMT_W];
  assign cout_o = cy[AMT_W];
endmodule

// File: rtl/acc_flag_eval.sv
module acc_flag_eval #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  output logic              z_o,
  output logic              n_o
);
  assign z_o = ~|res_i;
  assign n_o = res_i[DATA_W-1];
endmodule

// File: rtl/acc_rpt_ctrl.sv
// Pass sequencer: one pass on accept, then one per cycle while passes remain.
module acc_rpt_ctrl #(
  parameter int RPT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [RPT_W-1:0] rpt_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [RPT_W-1:0] left_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = load_o | busy_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        if (rpt_i == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          left_q <= rpt_i;
        end
      end else if (busy_q) begin
        left_q <= left_q - 1'b1;
        if (left_q == RPT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/acc_opc_match.sv
module acc_opc_match #(
  parameter int               OPC_W = 16,
  parameter logic [OPC_W-1:0] OPC   = 16'hFF51
) (
  input  logic [OPC_W-1:0] opcode_i,
  output logic             match_o
);
  assign match_o = (opcode_i == OPC);
endmodule

// File: rtl/acc_rshift_unit.sv
module acc_rshift_unit
  import acc_rshift_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sxm_i,
  input  logic [RPT_W-1:0]  rpt_i,
  input  logic [OPC_W-1:0]  opcode_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              z_o,
  output logic              n_o,
  output logic              c_o,
  output logic              done_o,
  output logic              match_o
);
  logic              load, step, busy;
  logic [DATA_W-1:0] acc_q, src, res;
  logic [AMT_W-1:0]  amt_q, amt;
  logic              sxm_q, arith, cout, z_nxt, n_nxt;
  flags_t            flg_q;

  acc_rpt_ctrl #(.RPT_W(RPT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .rpt_i,
    .load_o(load), .step_o(step), .busy_o(busy), .done_o
  );

  // operands come straight from the ports on the accepting cycle, from holds afterwards
  assign src   = load ? acc_i : acc_q;
  assign amt   = load ? cnt_i[AMT_W-1:0] : amt_q;
  assign arith = load ? sxm_i : sxm_q;

  acc_rshift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .din_i(src), .amt_i(amt), .arith_i(arith), .dout_o(res), .cout_o(cout)
  );

  acc_flag_eval #(.DATA_W(DATA_W)) u_flags (
    .res_i(res), .z_o(z_nxt), .n_o(n_nxt)
  );

  acc_opc_match #(.OPC_W(OPC_W), .OPC(OPC_SFR)) u_match (
    .opcode_i, .match_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      flg_q <= '0;
      amt_q <= '0;
      sxm_q <= 1'b0;
    end else begin
      if (load) begin
        amt_q <= cnt_i[AMT_W-1:0];
        sxm_q <= sxm_i;
      end
      if (step) begin
        acc_q <= res;
        flg_q <= '{z: z_nxt, n: n_nxt, c: cout};
      end
    end
  end

  assign acc_o = acc_q;
  assign z_o   = flg_q.z;
  assign n_o   = flg_q.n;
  assign c_o   = flg_q.c;
endmodule

// File: rtl/acc_rshift_chk.sv
module acc_rshift_chk
  import acc_rshift_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy,
  input logic [DATA_W-1:0] acc_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              sxm_i,
  input logic [RPT_W-1:0]  rpt_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              z_o,
  input logic              n_o,
  input logic              c_o,
  input logic              done_o
);
  logic accept;
  assign accept = start_i & ~busy;

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (z_o == (acc_o == '0))); // R3

  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (n_o == acc_o[DATA_W-1])); // R4

  AST_ZERO_AMT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cnt_i[AMT_W-1:0] == '0) |=> !c_o); // R5

  AST_LOGICAL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !sxm_i && cnt_i[AMT_W-1:0] != '0) |=> !acc_o[DATA_W-1]); // R2

  AST_ARITH_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sxm_i) |=> (acc_o[DATA_W-1] == $past(acc_i[DATA_W-1]))); // R2

  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && rpt_i == '0) |=> done_o); // R7

  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !done_o); // R8
endmodule

bind acc_rshift_unit acc_rshift_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy(busy),
  .acc_i(acc_i), .cnt_i(cnt_i), .sxm_i(sxm_i), .rpt_i(rpt_i),
  .acc_o(acc_o), .z_o(z_o), .n_o(n_o), .c_o(c_o), .done_o(done_o)
);

// File: tb/test_acc_rshift_unit.sv
`timescale 1ns/1ps
module test_acc_rshift_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, sxm = 1'b0;
  logic [31:0] acc_in = '0;
  logic [15:0] cnt = '0, opc = '0;
  logic [7:0]  rpt = '0;
  logic [31:0] acc_o;
  logic        z_o, n_o, c_o, done_o, match_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acc_rshift_unit i_acc_rshift_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_i(acc_in), .cnt_i(cnt),
    .sxm_i(sxm), .rpt_i(rpt), .opcode_i(opc), .acc_o, .z_o, .n_o, .c_o,
    .done_o, .match_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // bit-serial reference model
  logic [31:0] m_acc = '0;
  bit m_z = 0, m_n = 0, m_c = 0, m_done = 0, m_busy = 0, m_sxm = 0;
  int m_left = 0, m_amt = 0;

  task automatic m_pass(input logic [31:0] d_in);
    logic [31:0] d = d_in;
    bit c = 0;
    for (int i = 0; i < m_amt; i++) begin
      c = d[0];
      d = {(m_sxm ? d[31] : 1'b0), d[31:1]};
    end
    m_acc = d; m_z = (d == 0); m_n = d[31]; m_c = c;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_z = 0; m_n = 0; m_c = 0; m_done = 0; m_busy = 0; m_left = 0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        m_amt = int'(cnt) % 16; m_sxm = sxm;
        m_pass(acc_in);
        if (rpt == 0) m_done = 1;
        else begin m_busy = 1; m_left = int'(rpt); end
      end else if (m_busy) begin
        m_pass(m_acc);
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk(acc_o === m_acc, "R2 model acc", acc_o, m_acc);
      chk(z_o === m_z, "R3 model z", 32'(z_o), 32'(m_z));
      chk(n_o === m_n, "R4 model n", 32'(n_o), 32'(m_n));
      chk(c_o === m_c, "R5 model c", 32'(c_o), 32'(m_c));
      chk(done_o === m_done, "R7 model done", 32'(done_o), 32'(m_done));
      chk(match_o === (opc == 16'hFF51), "R9 model match", 32'(match_o), 32'(opc == 16'hFF51));
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [15:0] k, input bit s, input logic [7:0] r,
                        input logic [31:0] ea, input bit ez, input bit en, input bit ec, input string tag);
    @(negedge clk);
    acc_in = a; cnt = k; sxm = s; rpt = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < int'(r); i++) begin
      chk(done_o === 1'b0, {tag, " R6 early done"}, 32'(done_o), 0);
      @(negedge clk);
    end
    chk(done_o === 1'b1, {tag, " R7 done"}, 32'(done_o), 1);
    chk(acc_o === ea, {tag, " acc"}, acc_o, ea);
    chk(z_o === ez, {tag, " R3 z"}, 32'(z_o), 32'(ez));
    chk(n_o === en, {tag, " R4 n"}, 32'(n_o), 32'(en));
    chk(c_o === ec, {tag, " R5 c"}, 32'(c_o), 32'(ec));
    @(negedge clk);
    chk(done_o === 1'b0, {tag, " R7 pulse"}, 32'(done_o), 0);
  endtask

  initial begin
    #(8 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(acc_o === 0 && z_o === 0 && n_o === 0 && c_o === 0 && done_o === 0, "R10 reset",
        {acc_o[27:0], z_o, n_o, c_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 opcode compare
    opc = 16'hFF51; #1; chk(match_o === 1'b1, "R9 match", 32'(match_o), 1);
    opc = 16'hFF50; #1; chk(match_o === 1'b0, "R9 near miss", 32'(match_o), 0);
    opc = 16'h7F51; #1; chk(match_o === 1'b0, "R9 top bit", 32'(match_o), 0);
    // R1 upper count bits ignored, R2 arithmetic vs logical
    run_op(32'h8000_0010, 16'hFFF4, 1, 0, 32'hF800_0001, 0, 1, 0, "R1 R2 arith");
    run_op(32'h8000_0010, 16'h0004, 0, 0, 32'h0800_0001, 0, 0, 0, "R2 logical");
    run_op(32'h0000_0008, 16'h0004, 0, 0, 32'h0000_0000, 1, 0, 1, "R5 last bit out");
    run_op(32'h0000_0000, 16'h0010, 1, 0, 32'h0000_0000, 1, 0, 0, "R1 R3 zero amt");
    run_op(32'h8000_0001, 16'h00F0, 0, 0, 32'h8000_0001, 0, 1, 0, "R4 zero amt");
    run_op(32'h8000_0000, 16'h000F, 1, 2, 32'hFFFF_FFFF, 0, 1, 1, "R6 repeat arith");
    run_op(32'h0000_0100, 16'h0008, 0, 8'hFF, 32'h0000_0000, 1, 0, 0, "R6 max repeat");
    // R8 operand capture, mid-operation start ignored
    @(negedge clk);
    acc_in = 32'h8000_0000; cnt = 16'h0001; sxm = 0; rpt = 3; start = 1'b1;
    @(negedge clk);
    acc_in = 32'hFFFF_FFFF; cnt = 16'h0005; sxm = 1; rpt = 0;
    chk(done_o === 1'b0, "R8 busy 1", 32'(done_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 busy 2", 32'(done_o), 0);
    @(negedge clk);
    start = 1'b0;
    chk(done_o === 1'b0, "R8 busy 3", 32'(done_o), 0);
    @(negedge clk);
    chk(done_o === 1'b1, "R8 done", 32'(done_o), 1);
    chk(acc_o === 32'h0800_0000, "R8 held operands", acc_o, 32'h0800_0000);
    @(negedge clk);
    chk(done_o === 1'b0 && acc_o === 32'h0800_0000, "R8 no restart", acc_o, 32'h0800_0000);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule